// File: doc/BRIEF.md
# DMA Interrupt Routing and Error Unit

This block sits beside a multi-channel DMA engine. It decides which interrupt lines the interrupt controller sees. When a channel finishes, the block raises a completion request on the interrupt line of the peripheral that owns that channel. The one channel that software starts has its own line instead. While a peripheral is served by DMA, the block hides that peripheral's ordinary data-flow requests, so that a large transfer produces a single completion interrupt and not a stream of them. Error requests from the peripheral always pass through.

A bus or protection fault on a channel turns that channel off at once. The fault also sets a sticky flag, and the DMA error line follows that flag. A small register file holds the following state, all of it writable, readable, or both:

- a master enable;
- the per-channel enables;
- a per-channel completion status, cleared by writing 1;
- the sticky fault flag, cleared by writing 1;
- a control-table base pointer that only takes 1 KiB-aligned addresses.

A channel may run only while both its own enable and the master enable are set.

Top module: `dmairq_router`

## Requirements
- R1: A done pulse on any channel other than the last one (index NUM_CH-1) sets a request on peripheral line `c % NUM_PERIPH`. That `irq_per` bit is high from the cycle after the pulse.
- R2: A done pulse on the software channel (index NUM_CH-1) sets the request that drives `irq_sw`. It sets no peripheral line.
- R3: While `per_dma_en[p]` is 1, `per_data_irq[p]` does not reach `irq_per[p]`. While it is 0, it is passed through in the same cycle.
- R4: `per_err_irq[p]` is passed to `irq_per[p]` in the same cycle, whatever the value of `per_dma_en[p]`.
- R5: A done pulse on channel c sets bit c of the status register (address 2) from the next cycle.
- R6: `irq_ack[l]` clears the request of line l on the next edge. Lines 0..NUM_PERIPH-1 are the peripheral lines and line NUM_PERIPH is the software line. If a completion for that line arrives in the same cycle as the acknowledge, the request stays set.
- R7: A fault pulse on channel c clears bit c of the channel-enable register (address 1) on the next edge. The fault wins over a write to that register in the same cycle.
- R8: Any fault pulse sets the sticky flag, which is bit 0 of address 3. `irq_err` equals this flag. Writing a 1 to bit 0 clears the flag, unless a fault arrives in the same cycle.
- R9: Bit 0 of address 0 is the master enable. `ch_run` equals the channel enables while the master enable is 1, and is all zero while it is 0.
- R10: Address 4 holds the table base. Bits 31:10 store the written value. Bits 9:0 always read as 0.
- R11: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. A done pulse in the same cycle keeps the bit set.
- R12: After reset, every register reads 0 and every output is low. Reads of unused addresses (5 to 7) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_done | input | NUM_CH | Per-channel transfer-done pulse |
| ch_err | input | NUM_CH | Per-channel bus or protection fault pulse |
| per_data_irq | input | NUM_PERIPH | Peripheral data-flow interrupt requests |
| per_err_irq | input | NUM_PERIPH | Peripheral error interrupt requests (already unmasked) |
| per_dma_en | input | NUM_PERIPH | DMA service enable per peripheral |
| irq_ack | input | NUM_PERIPH+1 | Handler-activated acknowledge per completion line |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ch_run | output | NUM_CH | Channel permitted to operate |
| irq_per | output | NUM_PERIPH | Interrupt line per peripheral |
| irq_sw | output | 1 | Software-channel completion line |
| irq_err | output | 1 | DMA fault line |

## Verification
The embedded properties check the following on every cycle:

- the acknowledge-versus-completion precedence of each request line;
- a faulting channel losing its enable on the next edge;
- the sticky flag setting on a fault;
- status bits setting on completion;
- peripheral errors always passing through, and data requests staying hidden under DMA service.

Some behaviour can only be shown by the bench's scenarios. These are the mapping of channels onto peripheral lines, the write-one-to-clear rules, precedence between register writes and hardware events, and the aligned base readback. The bench shows them by comparing every output against a reference model while random traffic and directed collisions are driven.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

    localparam int unsigned DATA_W          = 32;
    localparam int unsigned ADDR_W          = 3;
    localparam int unsigned BASE_ALIGN_BITS = 10;

    typedef enum logic [ADDR_W-1:0] {
        RA_CFG  = 3'd0,
        RA_CHEN = 3'd1,
        RA_STAT = 3'd2,
        RA_ERR  = 3'd3,
        RA_BASE = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } reg_req_t;

    // Peripheral line that owns a given (non-software) channel
    function automatic int unsigned owner_of(input int unsigned ch, input int unsigned np);
        return ch % np;
    endfunction

endpackage

// File: rtl/dmairq_regs.sv
module dmairq_regs
    import dmairq_pkg::*;
#(
    parameter int unsigned NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_req_t          req,
    input  logic [NUM_CH-1:0] ch_done,
    input  logic [NUM_CH-1:0] ch_err,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CH-1:0] ch_run,
    output logic              err_flag
);
    localparam int unsigned BASE_W = DATA_W - BASE_ALIGN_BITS;

    logic              master_q;
    logic [NUM_CH-1:0] chen_q;
    logic [NUM_CH-1:0] stat_q;
    logic              err_q;
    logic [BASE_W-1:0] base_q;

    logic wr_cfg, wr_chen, wr_stat, wr_err, wr_base;

    always_comb begin
        wr_cfg  = req.wr && (req.addr == RA_CFG);
        wr_chen = req.wr && (req.addr == RA_CHEN);
        wr_stat = req.wr && (req.addr == RA_STAT);
        wr_err  = req.wr && (req.addr == RA_ERR);
        wr_base = req.wr && (req.addr == RA_BASE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            master_q <= 1'b0;
            chen_q   <= '0;
            stat_q   <= '0;
            err_q    <= 1'b0;
            base_q   <= '0;
        end else begin
            if (wr_cfg)
                master_q <= req.data[0];
            // Fault disables win over a software write in the same cycle
            chen_q <= (wr_chen ? req.data[NUM_CH-1:0] : chen_q) & ~ch_err;
            // Write-one-to-clear, new completions win
            stat_q <= (wr_stat ? (stat_q & ~req.data[NUM_CH-1:0]) : stat_q) | ch_done;
            // Sticky flag, clear by 1, new faults win
            err_q  <= (|ch_err) | (err_q & ~(wr_err & req.data[0]));
            if (wr_base)
                base_q <= req.data[DATA_W-1:BASE_ALIGN_BITS];
        end
    end

    always_comb begin
        rdata = '0;
        unique case (req.addr)
            RA_CFG:  rdata[0]          = master_q;
            RA_CHEN: rdata[NUM_CH-1:0] = chen_q;
            RA_STAT: rdata[NUM_CH-1:0] = stat_q;
            RA_ERR:  rdata[0]          = err_q;
            RA_BASE: rdata = {base_q, {BASE_ALIGN_BITS{1'b0}}};
            default: rdata = '0;
        endcase
    end

    assign ch_run   = chen_q & {NUM_CH{master_q}};
    assign err_flag = err_q;

    AST_FAULT_DISABLES: assert property (@(posedge clk) disable iff (rst)
        (|ch_err) |=> ((chen_q & $past(ch_err)) == '0)) else $error("fault did not disable channel"); // R7
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (|ch_err) |=> err_q) else $error("fault flag not set"); // R8
    AST_DONE_STATUS: assert property (@(posedge clk) disable iff (rst)
        (|ch_done) |=> ((stat_q & $past(ch_done)) == $past(ch_done))) else $error("status not set"); // R5

endmodule

// File: rtl/dmairq_cmpl.sv
module dmairq_cmpl
    import dmairq_pkg::*;
#(
    parameter int unsigned NUM_CH     = 8,
    parameter int unsigned NUM_PERIPH = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_CH-1:0]     ch_done,
    input  logic [NUM_PERIPH:0]   ack,
    output logic [NUM_PERIPH:0]   req
);
    localparam int unsigned NUM_LINES = NUM_PERIPH + 1;
    localparam int unsigned SW_CH     = NUM_CH - 1;

    logic [NUM_LINES-1:0] set_line;
    logic [NUM_LINES-1:0] req_q;

    always_comb begin
        set_line = '0;
        for (int unsigned c = 0; c < SW_CH; c++)
            set_line[owner_of(c, NUM_PERIPH)] = set_line[owner_of(c, NUM_PERIPH)] | ch_done[c];
        set_line[NUM_PERIPH] = ch_done[SW_CH];
    end

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst)
                req_q[l] <= 1'b0;
            else
                req_q[l] <= set_line[l] | (req_q[l] & ~ack[l]);
        end

        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
            (ack[l] && !set_line[l]) |=> !req_q[l]) else $error("ack did not clear"); // R6
        AST_DONE_WINS: assert property (@(posedge clk) disable iff (rst)
            set_line[l] |=> req_q[l]) else $error("completion lost"); // R6
    end

    assign req = req_q;

endmodule

// File: rtl/dmairq_route.sv
module dmairq_route #(
    parameter int unsigned NUM_PERIPH = 4
) (
    input  logic [NUM_PERIPH:0]   req,
    input  logic [NUM_PERIPH-1:0] per_data_irq,
    input  logic [NUM_PERIPH-1:0] per_err_irq,
    input  logic [NUM_PERIPH-1:0] per_dma_en,
    input  logic                  err_flag,
    output logic [NUM_PERIPH-1:0] irq_per,
    output logic                  irq_sw,
    output logic                  irq_err
);
    for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_per
        assign irq_per[p] = req[p] | per_err_irq[p] | (per_data_irq[p] & ~per_dma_en[p]);
    end

    assign irq_sw  = req[NUM_PERIPH];
    assign irq_err = err_flag;

endmodule

// File: rtl/dmairq_router.sv
module dmairq_router
    import dmairq_pkg::*;
#(
    parameter int unsigned NUM_CH     = 8,
    parameter int unsigned NUM_PERIPH = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_CH-1:0]     ch_done,
    input  logic [NUM_CH-1:0]     ch_err,
    input  logic [NUM_PERIPH-1:0] per_data_irq,
    input  logic [NUM_PERIPH-1:0] per_err_irq,
    input  logic [NUM_PERIPH-1:0] per_dma_en,
    input  logic [NUM_PERIPH:0]   irq_ack,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic [NUM_CH-1:0]     ch_run,
    output logic [NUM_PERIPH-1:0] irq_per,
    output logic                  irq_sw,
    output logic                  irq_err
);
    reg_req_t              bus;
    logic [NUM_PERIPH:0]   cmpl_req;
    logic                  err_flag;

    assign bus = '{wr: reg_wr, addr: reg_addr, data: reg_wdata};

    dmairq_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .req      (bus),
        .ch_done  (ch_done),
        .ch_err   (ch_err),
        .rdata    (reg_rdata),
        .ch_run   (ch_run),
        .err_flag (err_flag)
    );

    dmairq_cmpl #(.NUM_CH(NUM_CH), .NUM_PERIPH(NUM_PERIPH)) u_cmpl (
        .clk     (clk),
        .rst     (rst),
        .ch_done (ch_done),
        .ack     (irq_ack),
        .req     (cmpl_req)
    );

    dmairq_route #(.NUM_PERIPH(NUM_PERIPH)) u_route (
        .req          (cmpl_req),
        .per_data_irq (per_data_irq),
        .per_err_irq  (per_err_irq),
        .per_dma_en   (per_dma_en),
        .err_flag     (err_flag),
        .irq_per      (irq_per),
        .irq_sw       (irq_sw),
        .irq_err      (irq_err)
    );

    for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_chk
        AST_ERR_FORWARD: assert property (@(posedge clk) disable iff (rst)
            per_err_irq[p] |-> irq_per[p]) else $error("peripheral error dropped"); // R4
        AST_DATA_HIDDEN: assert property (@(posedge clk) disable iff (rst)
            (per_data_irq[p] && per_dma_en[p] && !per_err_irq[p] && !cmpl_req[p]) |-> !irq_per[p])
            else $error("data request leaked under DMA"); // R3
    end

endmodule

// File: tb/dmairq_router_bench.sv
module dmairq_router_bench;
    localparam int NCH = 8;
    localparam int NP  = 4;
    localparam int NL  = NP + 1;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NCH-1:0]  ch_done = '0, ch_err = '0;
    logic [NP-1:0]   per_data_irq = '0, per_err_irq = '0, per_dma_en = '0;
    logic [NL-1:0]   irq_ack = '0;
    logic            reg_wr = 1'b0;
    logic [2:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NCH-1:0]  ch_run;
    logic [NP-1:0]   irq_per;
    logic            irq_sw, irq_err;

    always #2.5 clk = ~clk;

    dmairq_router #(.NUM_CH(NCH), .NUM_PERIPH(NP)) u_dmairq_router (
        .clk(clk), .rst(rst), .ch_done(ch_done), .ch_err(ch_err),
        .per_data_irq(per_data_irq), .per_err_irq(per_err_irq), .per_dma_en(per_dma_en),
        .irq_ack(irq_ack), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ch_run(ch_run), .irq_per(irq_per), .irq_sw(irq_sw), .irq_err(irq_err)
    );

    int n_cmp = 0, n_bad = 0;
    bit done_flag = 0;

    // Reference model state
    logic           m_master;
    logic [NCH-1:0] m_chen, m_stat;
    logic           m_err;
    logic [21:0]    m_base;
    logic [NL-1:0]  m_req;

    function automatic logic [NL-1:0] lines_of(input logic [NCH-1:0] d);
        logic [NL-1:0] s = '0;
        for (int c = 0; c < NCH-1; c++) if (d[c]) s[c % NP] = 1'b1;  // R1 mapping
        s[NP] = d[NCH-1];                                             // R2 software line
        return s;
    endfunction

    function automatic logic [31:0] exp_rdata(input logic [2:0] a);
        logic [31:0] r = '0;
        case (a)
            3'd0: r[0] = m_master;
            3'd1: r[NCH-1:0] = m_chen;
            3'd2: r[NCH-1:0] = m_stat;
            3'd3: r[0] = m_err;
            3'd4: r = {m_base, 10'd0};
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic model_reset();
        m_master = 0; m_chen = '0; m_stat = '0; m_err = 0; m_base = '0; m_req = '0;
    endtask

    task automatic model_update();
        m_req = (m_req & ~irq_ack) | lines_of(ch_done);
        if (reg_wr) begin
            case (reg_addr)
                3'd0: m_master = reg_wdata[0];
                3'd1: m_chen = reg_wdata[NCH-1:0];
                3'd2: m_stat = m_stat & ~reg_wdata[NCH-1:0];
                3'd3: if (reg_wdata[0]) m_err = 1'b0;
                3'd4: m_base = reg_wdata[31:10];
                default: ;
            endcase
        end
        m_stat = m_stat | ch_done;
        m_chen = m_chen & ~ch_err;
        if (|ch_err) m_err = 1'b1;
    endtask

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic [NP-1:0] ep;
        for (int p = 0; p < NP; p++)
            ep[p] = m_req[p] | per_err_irq[p] | (per_data_irq[p] & ~per_dma_en[p]);
        cmp("R1/R3/R4/R6 irq_per", 32'(irq_per), 32'(ep));
        cmp("R2/R6 irq_sw", 32'(irq_sw), 32'(m_req[NP]));
        cmp("R8 irq_err", 32'(irq_err), 32'(m_err));
        cmp("R7/R9 ch_run", 32'(ch_run), 32'(m_chen & {NCH{m_master}}));
        case (reg_addr)
            3'd0: cmp("R9 cfg read", reg_rdata, exp_rdata(reg_addr));
            3'd1: cmp("R7 chen read", reg_rdata, exp_rdata(reg_addr));
            3'd2: cmp("R5/R11 status read", reg_rdata, exp_rdata(reg_addr));
            3'd3: cmp("R8 flag read", reg_rdata, exp_rdata(reg_addr));
            3'd4: cmp("R10 base read", reg_rdata, exp_rdata(reg_addr));
            default: cmp("R12 unused read", reg_rdata, exp_rdata(reg_addr));
        endcase
    endtask

    // Inputs are set at negedge; check, then clock once and update the model
    task automatic step();
        #1 check_all();
        @(posedge clk);
        if (rst) model_reset(); else model_update();
        @(negedge clk);
    endtask

    task automatic idle();
        ch_done = '0; ch_err = '0; irq_ack = '0; reg_wr = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        @(negedge clk);
        step(); step();
        rst = 0;
        // R12: reset state of every address
        for (int a = 0; a < 8; a++) begin reg_addr = 3'(a); step(); end

        // R10: base keeps only bits 31:10
        wr(3'd4, 32'hFFFF_FFFF); step(); idle(); reg_addr = 3'd4; step();
        // R9: master enable with channels enabled
        wr(3'd1, 32'h0000_00FF); step(); wr(3'd0, 32'h1); step(); idle(); step();
        // R1/R5: channel 5 owned by line 1
        ch_done = 8'h20; reg_addr = 3'd2; step(); idle(); step();
        // R6: ack line 1 with a new completion on channel 1 in same cycle
        irq_ack = 5'b00010; ch_done = 8'h02; step(); idle(); step();
        irq_ack = 5'b00010; step(); idle(); step();
        // R2: software channel
        ch_done = 8'h80; step(); idle(); step(); irq_ack = 5'b10000; step(); idle(); step();
        // R11: write zero has no effect, then W1C with simultaneous done
        wr(3'd2, 32'h0); step(); wr(3'd2, 32'hFF); ch_done = 8'h20; step(); idle(); reg_addr = 3'd2; step();
        // R7: fault beats a write enabling the same channel
        wr(3'd1, 32'hFF); ch_err = 8'h08; step(); idle(); reg_addr = 3'd1; step();
        // R8: clear with a fault in the same cycle stays set, then clean clear
        wr(3'd3, 32'h1); ch_err = 8'h01; step(); idle(); reg_addr = 3'd3; step();
        wr(3'd3, 32'h1); step(); idle(); reg_addr = 3'd3; step();
        // R3/R4: data masked under DMA, error forwarded
        per_dma_en = 4'b0101; per_data_irq = 4'b1111; step();
        per_data_irq = 4'b0000; per_err_irq = 4'b0101; step();
        per_err_irq = '0; per_dma_en = '0; step();

        // Random traffic, compared against the model every cycle (R1-R12)
        for (int i = 0; i < 4000; i++) begin
            for (int c = 0; c < NCH; c++) begin
                ch_done[c] = ($urandom % 10) == 0;
                ch_err[c]  = ($urandom % 60) == 0;
            end
            per_data_irq = 4'($urandom);
            per_err_irq  = 4'($urandom) & 4'($urandom);
            per_dma_en   = 4'($urandom);
            irq_ack      = 5'($urandom) & 5'($urandom);
            reg_addr     = 3'($urandom % 8);
            reg_wr       = ($urandom % 5) == 0;
            reg_wdata    = $urandom;
            if (reg_addr == 3'd0 && ($urandom % 4) != 0) reg_wdata[0] = 1'b1;
            step();
        end
        idle(); step();

        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule